// File: doc/BRIEF.md
# Receiver Lock and Output Gating Controller

This block decides when the parallel outputs of a serial-link receiver may carry data. It watches an active-low power-down control and the incoming parallel-rate clock, and it judges the clock against a free-running reference clock. After power-up the block counts a fixed number of input-clock periods before it releases data. Until then it drives every output low. It also drives them low whenever the input clock stops or runs too slowly.

While power-down is asserted the outputs float. This is modelled here by a deasserted output-enable, so two receivers can share one output bus. A build parameter selects the strobe polarity. With one setting the output strobe marks valid data on its rising edge. With the other the strobe is inverted, so the data is marked on its falling edge. The strobe follows the input clock, which is synchronized into the reference domain.

The block has four states: POWERDOWN, ACQUIRE, LOCKED and NOCLOCK. The clock multiplier and the pad drivers sit outside the block.

Top module: `rx_lock_gate`

## Requirements
- R1: While `run_en` is low, or while `rst_n` is low, `out_en` is 0, `dout` is all zeros and `strobe` is 0.
- R2: When `run_en` is sampled low on a reference-clock edge, the block is in POWERDOWN after that edge, whatever state it was in before.
- R3: After `run_en` goes high, `out_en` is 1 and `dout` stays all zeros until LOCK_EDGES input-clock rising edges have been detected. The block is then LOCKED.
- R4: In LOCKED, `dout` equals `din` in the same cycle. In every other state `dout` is all zeros.
- R5: If no input-clock rising edge is detected for MISS_LIMIT reference cycles, the block enters NOCLOCK. Outputs are then zero and `out_en` stays 1. The first edge seen after that starts a new acquisition.
- R6: An input clock whose period is longer than MISS_LIMIT reference cycles never reaches LOCKED, so `dout` stays zero.
- R7: The lock count restarts from zero when the block leaves POWERDOWN and when it enters NOCLOCK. A partial count made before either event does not carry over.
- R8: With STROBE_RISE=1, `strobe` follows the synchronized input clock while LOCKED. With STROBE_RISE=0 it is the inverse of that clock. In any other state `strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Active-low power-down: low = power down, high = run |
| lane_clk | input | 1 | Incoming parallel-rate clock, asynchronous to `clk` |
| din | input | DATA_W | Recovered parallel data |
| dout | output | DATA_W | Gated parallel data |
| out_en | output | 1 | Output enable; 0 models the high-impedance state |
| strobe | output | 1 | Output strobe with build-selected polarity |

## Verification
Some properties are checked on every cycle:
- a low `run_en` forces POWERDOWN on the next edge;
- LOCKED is entered only from ACQUIRE;
- a detected missing clock in LOCKED leads to NOCLOCK;
- the lock counter is zero outside acquisition;
- data and strobe are quiet unless locked, and output-enable is off in POWERDOWN.

Other behaviours need the bench's scenarios:
- the exact lock count;
- the restart of the count after power-down or a clock loss;
- the rejection of a slow clock;
- the complementary strobes of the two polarity builds.

// File: rtl/rx_lock_pkg.sv
`timescale 1ns/1ps
package rx_lock_pkg;
    typedef enum logic [1:0] {
        ST_PDOWN = 2'd0,
        ST_ACQ   = 2'd1,
        ST_LOCK  = 2'd2,
        ST_NOCLK = 2'd3
    } lk_state_e;
endpackage

// File: rtl/rx_clk_monitor.sv
`timescale 1ns/1ps
module rx_clk_monitor #(
    parameter int MISS_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lane_clk,
    output logic edge_seen,
    output logic clk_missing,
    output logic lane_sync
);
    localparam int MW = $clog2(MISS_LIMIT + 1);

    typedef struct packed {
        logic [2:0]    shr;
        logic [MW-1:0] miss;
    } mon_t;

    mon_t mon_d, mon_q;

    assign edge_seen   = mon_q.shr[1] & ~mon_q.shr[2];
    assign lane_sync   = mon_q.shr[1];
    assign clk_missing = (mon_q.miss == MW'(MISS_LIMIT));

    always_comb begin
        mon_d     = mon_q;
        mon_d.shr = {mon_q.shr[1:0], lane_clk};
        if (edge_seen)
            mon_d.miss = '0;
        else if (!clk_missing)
            mon_d.miss = mon_q.miss + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    // R5: the idle counter saturates at the limit
    a_r5_miss_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q.miss <= MW'(MISS_LIMIT));

    // R5: a detected edge removes the missing indication
    a_r5_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> !clk_missing);
endmodule

// File: rtl/rx_lock_fsm.sv
`timescale 1ns/1ps
module rx_lock_fsm
    import rx_lock_pkg::*;
#(
    parameter int LOCK_EDGES = 32800
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_en,
    input  logic      edge_seen,
    input  logic      clk_missing,
    output lk_state_e state
);
    localparam int CW = $clog2(LOCK_EDGES + 1);

    typedef struct packed {
        lk_state_e     st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    assign state = fsm_q.st;

    always_comb begin
        fsm_d = fsm_q;
        if (!run_en) begin
            fsm_d.st  = ST_PDOWN;
            fsm_d.cnt = '0;
        end else begin
            unique case (fsm_q.st)
                ST_PDOWN: begin
                    fsm_d.st  = ST_ACQ;
                    fsm_d.cnt = '0;
                end
                ST_ACQ: begin
                    if (clk_missing) begin
                        fsm_d.st  = ST_NOCLK;
                        fsm_d.cnt = '0;
                    end else if (edge_seen) begin
                        if (fsm_q.cnt == CW'(LOCK_EDGES - 1)) begin
                            fsm_d.st  = ST_LOCK;
                            fsm_d.cnt = '0;
                        end else begin
                            fsm_d.cnt = fsm_q.cnt + 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    if (clk_missing) begin
                        fsm_d.st  = ST_NOCLK;
                        fsm_d.cnt = '0;
                    end
                end
                ST_NOCLK: begin
                    if (edge_seen) begin
                        fsm_d.st  = ST_ACQ;
                        fsm_d.cnt = '0;
                    end
                end
                default: begin
                    fsm_d.st  = ST_PDOWN;
                    fsm_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_PDOWN, cnt: '0};
        else        fsm_q <= fsm_d;
    end

    // R2: power-down overrides every state on the next edge
    a_r2_pd_direct: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> fsm_q.st == ST_PDOWN);

    // R3: lock is reached only through acquisition
    a_r3_lock_from_acq: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st != ST_LOCK) ##1 (fsm_q.st == ST_LOCK) |-> $past(fsm_q.st) == ST_ACQ);

    // R5: clock loss while locked drops lock
    a_r5_loss_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && fsm_q.st == ST_LOCK && clk_missing) |=> fsm_q.st == ST_NOCLK);

    // R7: the counter holds a value only during acquisition
    a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st != ST_ACQ) |-> fsm_q.cnt == '0);
endmodule

// File: rtl/rx_out_gate.sv
`timescale 1ns/1ps
module rx_out_gate
    import rx_lock_pkg::*;
#(
    parameter int DATA_W      = 21,
    parameter bit STROBE_RISE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lk_state_e         state,
    input  logic [DATA_W-1:0] din,
    input  logic              lane_sync,
    output logic [DATA_W-1:0] dout,
    output logic              out_en,
    output logic              strobe
);
    logic strobe_raw;

    generate
        if (STROBE_RISE) begin : g_rise
            assign strobe_raw = lane_sync;
        end else begin : g_fall
            assign strobe_raw = ~lane_sync;
        end
    endgenerate

    always_comb begin
        out_en = (state != ST_PDOWN);
        dout   = (state == ST_LOCK) ? din : '0;
        strobe = (state == ST_LOCK) ? strobe_raw : 1'b0;
    end

    // R4: nonzero data appears only when locked
    a_r4_data_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != '0) |-> state == ST_LOCK);

    // R1: power-down releases the outputs
    a_r1_hiz_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDOWN) |-> (!out_en && dout == '0));

    // R8: the strobe is quiet while unlocked
    a_r8_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOCK) |-> !strobe);
endmodule

// File: rtl/rx_lock_gate.sv
`timescale 1ns/1ps
module rx_lock_gate
    import rx_lock_pkg::*;
#(
    parameter int DATA_W      = 21,
    parameter int LOCK_EDGES  = 32800,
    parameter int MISS_LIMIT  = 64,
    parameter bit STROBE_RISE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              lane_clk,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              out_en,
    output logic              strobe
);
    logic      edge_seen;
    logic      clk_missing;
    logic      lane_sync;
    lk_state_e state;

    rx_clk_monitor #(.MISS_LIMIT(MISS_LIMIT)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_clk    (lane_clk),
        .edge_seen   (edge_seen),
        .clk_missing (clk_missing),
        .lane_sync   (lane_sync)
    );

    rx_lock_fsm #(.LOCK_EDGES(LOCK_EDGES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .edge_seen   (edge_seen),
        .clk_missing (clk_missing),
        .state       (state)
    );

    rx_out_gate #(.DATA_W(DATA_W), .STROBE_RISE(STROBE_RISE)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .din       (din),
        .lane_sync (lane_sync),
        .dout      (dout),
        .out_en    (out_en),
        .strobe    (strobe)
    );
endmodule

// File: tb/test_rx_lock_gate.sv
`timescale 1ns/1ps
module test_rx_lock_gate;
    localparam int DW   = 21;
    localparam int LOCK = 16;
    localparam int MISS = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          lane_clk = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout, dout_f;
    logic          out_en, out_en_f, strobe, strobe_f;
    int            lane_half = 20;
    int            n_chk = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    initial begin
        #2;
        forever begin
            if (lane_half == 0) begin
                lane_clk = 1'b0;
                #4;
            end else begin
                #(lane_half) lane_clk = ~lane_clk;
            end
        end
    end

    rx_lock_gate #(.DATA_W(DW), .LOCK_EDGES(LOCK), .MISS_LIMIT(MISS), .STROBE_RISE(1'b1)) i_rx_lock_gate (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .lane_clk(lane_clk),
        .din(din), .dout(dout), .out_en(out_en), .strobe(strobe));

    rx_lock_gate #(.DATA_W(DW), .LOCK_EDGES(LOCK), .MISS_LIMIT(MISS), .STROBE_RISE(1'b0)) i_rx_lock_gate_fall (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .lane_clk(lane_clk),
        .din(din), .dout(dout_f), .out_en(out_en_f), .strobe(strobe_f));

    task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lane_edges(input int n);
        repeat (n) @(posedge lane_clk);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic          run;
        logic [7:0]    half;
        logic [DW-1:0] data;
        logic          pass;
        logic          oe;
    } vec_t;

    // pass=1: dout must equal din (R4); otherwise zero
    localparam vec_t VECS [7] = '{
        '{1'b1, 8'd20,  21'h0A5A5, 1'b1, 1'b1},  // R3 R4 lock then pass
        '{1'b1, 8'd20,  21'h1F234, 1'b1, 1'b1},  // R4 new pattern
        '{1'b1, 8'd0,   21'h15555, 1'b0, 1'b1},  // R5 stopped clock
        '{1'b1, 8'd20,  21'h0ABCD, 1'b1, 1'b1},  // R5 relock
        '{1'b1, 8'd120, 21'h13579, 1'b0, 1'b1},  // R6 slow clock
        '{1'b0, 8'd20,  21'h1FFFF, 1'b0, 1'b0},  // R1 power-down
        '{1'b1, 8'd20,  21'h00F0F, 1'b1, 1'b1}   // R3 recover
    };

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        din = 21'h1AAAA;
        repeat (3) @(negedge clk);
        check("R1 reset out_en", {{DW{1'b0}}, out_en}, '0);
        check("R1 reset dout", {1'b0, dout}, '0);
        check("R1 reset strobe", {{DW{1'b0}}, strobe}, '0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 run_en low dout", {out_en, dout}, '0);

        foreach (VECS[i]) begin
            run_en    = VECS[i].run;
            lane_half = int'(VECS[i].half);
            din       = VECS[i].data;
            #1200;
            @(negedge clk);
            check($sformatf("vector %0d dout (R1 R4 R5 R6)", i), {1'b0, dout},
                  VECS[i].pass ? {1'b0, VECS[i].data} : '0);
            check($sformatf("vector %0d out_en (R1 R5)", i), {{DW{1'b0}}, out_en},
                  {{DW{1'b0}}, VECS[i].oe});
        end

        // R3 exact count boundary
        din = 21'h12345;
        run_en = 1'b0;
        lane_half = 20;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        lane_edges(LOCK - 2);
        check("R3 not locked before count", {out_en, dout}, {1'b1, {DW{1'b0}}});
        lane_edges(3);
        repeat (3) @(negedge clk);
        check("R3 locked after count", {out_en, dout}, {1'b1, din});

        // R8 strobe polarity builds
        for (int k = 0; k < 8; k++) begin
            #13;
            @(negedge clk);
            check("R8 strobes complementary", {{DW{1'b0}}, strobe}, {{DW{1'b0}}, ~strobe_f});
        end

        // R2 power-down from LOCKED within one edge
        run_en = 1'b0;
        @(negedge clk);
        check("R2 power-down direct", {out_en, dout}, '0);
        check("R8 strobe quiet in power-down", {{DW{1'b0}}, strobe | strobe_f}, '0);

        // R7 count restarts after power-down
        run_en = 1'b1;
        lane_edges(10);
        run_en = 1'b0;
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        lane_edges(LOCK - 2);
        check("R7 count cleared by power-down", {out_en, dout}, {1'b1, {DW{1'b0}}});
        lane_edges(3);
        repeat (3) @(negedge clk);
        check("R7 lock after fresh count", {1'b0, dout}, {1'b0, din});

        // R7 count restarts after clock loss
        run_en = 1'b0;
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        lane_edges(10);
        lane_half = 0;
        repeat (MISS + 6) @(negedge clk);
        check("R5 loss during acquire", {out_en, dout}, {1'b1, {DW{1'b0}}});
        lane_half = 20;
        lane_edges(LOCK - 2);
        check("R7 count cleared by clock loss", {1'b0, dout}, '0);
        lane_edges(3);
        repeat (3) @(negedge clk);
        check("R7 relock after loss", {1'b0, dout}, {1'b0, din});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule